// File: doc/BRIEF.md
# Glitch-Free Clock Output Stop and Enable Controller

This block decides, for each of a set of differential clock output pairs, whether the pair runs, parks at a fixed level, or floats. The output clock is built from a reference clock `clk`. A two-bit phase counter drives it, so one output period is 2 `clk` cycles at the normal rate and 4 `clk` cycles at the divide-by-2 rate. For every pair the block produces a registered true value, a complement value, and a separate drive enable for each leg. An analog output stage outside this block consumes these signals.

The asynchronous pins are resynchronised into the `clk` domain. These pins are the stop request, the per-output enable pins and the divide pin. A polarity strap selects the active level of the stop pin and of the enable pins. The stop request is accepted only once it is stable across two consecutive sample points. A sample point is a rising edge of the complement output clock, which is the same as a falling edge of the true clock. Every change of state is timed to a transition of the output clock, so that no output emits a shortened pulse. These changes are: parking, resuming, enabling, disabling and switching rate.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: A change of the synchronised, polarity-corrected stop request takes effect only after it has held the same value at two consecutive falling edges of the true output clock. A pulse that spans at most one such edge has no effect on any output.
- R2: Polarity strap behaviour:
  - When `pol_strap` is 0, the stop pin is active low and the enable pins are active high.
  - When `pol_strap` is 1, the stop pin is active high and the enable pins are active low.
- R3: Only outputs whose `reg_stoppable` bit is 1 react to an accepted stop request. Every other enabled output keeps toggling.
- R4: A stopped output parks after a rising transition of its true leg.
  - When `park_hiz` is 0, it holds `out_t`=1 with `drv_t`=1 and `drv_c`=0.
  - When `park_hiz` is 1, both drive enables are 0 and both data values are 0.
- R5: An output is disabled when its enable pin is inactive, or its `reg_en` bit is 0, or both. A disabled output has both drive enables at 0 and both data values at 0, whether or not a stop is requested.
- R6: After a stop is released, all parked outputs resume in the same `clk` cycle. This happens within 6 output periods of the pin change.
- R7: Divide-by-2 is selected when `div_pin_n` is 0 or `reg_div_n` is 0. A running true leg toggles every `clk` cycle at the normal rate and every second cycle at the divide-by-2 rate. The new rate is in place within 6 output periods.
- R8: Restarts and rate changes happen only at the start of a low phase. A restarting output's first driven value is `out_t`=0. No high or low phase of a running output is ever longer than 2 cycles.
- R9: While `rst` is high, the block registers all drive enables at 0 and all data values at 0.
- R10: While the complement leg is driven, `out_c` is the inverse of `out_t`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the output clock is derived from it |
| rst | input | 1 | Synchronous active-high reset |
| stop_pin | input | 1 | Asynchronous clock-stop request; active level set by `pol_strap` |
| oe_pin | input | NOUT | Asynchronous per-output enable pins; active level set by `pol_strap` |
| pol_strap | input | 1 | Polarity strap for the stop and enable pins |
| reg_en | input | NOUT | Per-output register enable (1 = enabled) |
| reg_stoppable | input | NOUT | Per-output stoppable bit (1 = reacts to stop) |
| park_hiz | input | 1 | Park drive mode: 0 = true leg driven high, 1 = both legs undriven |
| div_pin_n | input | 1 | Asynchronous divide request, active low |
| reg_div_n | input | 1 | Register divide request, active low |
| out_t | output | NOUT | True-leg data per output |
| out_c | output | NOUT | Complement-leg data per output |
| drv_t | output | NOUT | True-leg drive enable per output |
| drv_c | output | NOUT | Complement-leg drive enable per output |

## Verification
The main sweep covers the following, with every output classified as off, parked or running:
- both strap levels, both park modes and all three rate sources;
- the stop request asserted and idle;
- three rotations of the enable-pin, enable-register and stoppable patterns, so that the eight outputs together cover every combination of those three bits.

Toggle counts over a 17-sample window separate the normal rate from the divide-by-2 rate. Short stop pulses at both rates separate a correct two-sample debounce from a single-sample one. A release from the parked state shows whether the outputs resume together and start low. A run of rate switches every 13 cycles exposes any high or low phase stretched by a badly timed switch.

// File: rtl/clkout_gate_pkg.sv
package clkout_gate_pkg;
  // Per-output gating state
  typedef enum logic [1:0] {
    GS_OFF  = 2'd0,   // both legs undriven
    GS_RUN  = 2'd1,   // following the reference phase
    GS_PARK = 2'd2    // stopped, held at the park level
  } gate_st_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rate_gen.sv
module rate_gen (
  input  logic clk,
  input  logic rst,
  input  logic div_req,
  output logic ref_next,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int PW = 2;

  logic [PW-1:0] ph_q, ph_n;
  logic          half_q, half_n;
  logic          ref_q;

  always_comb begin
    ph_n     = ph_q + PW'(1);
    // the rate may only change where both rates start a low phase together
    half_n   = (ph_q == {PW{1'b1}}) ? div_req : half_q;
    ref_next = half_n ? ph_n[1] : ph_n[0];
    rise_ev  = ~ref_q & ref_next;
    fall_ev  = ref_q & ~ref_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= '0;
      half_q <= 1'b0;
      ref_q  <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      half_q <= half_n;
      ref_q  <= ref_next;
    end
  end
endmodule

// File: rtl/stop_debounce.sv
module stop_debounce (
  input  logic clk,
  input  logic rst,
  input  logic sample,
  input  logic level,
  output logic held
);
  logic last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b0;
      held   <= 1'b0;
    end else if (sample) begin
      last_q <= level;
      if (level == last_q) held <= level;
    end
  end
endmodule

// File: rtl/out_gate.sv
module out_gate
  import clkout_gate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rise_ev,
  input  logic fall_ev,
  input  logic ref_next,
  input  logic en,
  input  logic stop_req,
  input  logic park_hiz,
  output logic o_t,
  output logic o_c,
  output logic d_t,
  output logic d_c
);
  gate_st_e st_q, st_n;

  always_comb begin
    st_n = st_q;
    if (fall_ev) begin
      if (!en)                            st_n = GS_OFF;
      else if (st_q == GS_OFF)            st_n = GS_RUN;
      else if (st_q == GS_PARK && !stop_req) st_n = GS_RUN;
    end else if (rise_ev && st_q == GS_RUN && en && stop_req) begin
      st_n = GS_PARK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= GS_OFF;
      o_t  <= 1'b0;
      o_c  <= 1'b0;
      d_t  <= 1'b0;
      d_c  <= 1'b0;
    end else begin
      st_q <= st_n;
      unique case (st_n)
        GS_RUN: begin
          o_t <= ref_next;
          o_c <= ~ref_next;
          d_t <= 1'b1;
          d_c <= 1'b1;
        end
        GS_PARK: begin
          o_t <= ~park_hiz;
          o_c <= 1'b0;
          d_t <= ~park_hiz;
          d_c <= 1'b0;
        end
        default: begin
          o_t <= 1'b0;
          o_c <= 1'b0;
          d_t <= 1'b0;
          d_c <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl #(
  parameter int NOUT        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stop_pin,
  input  logic [NOUT-1:0] oe_pin,
  input  logic            pol_strap,
  input  logic [NOUT-1:0] reg_en,
  input  logic [NOUT-1:0] reg_stoppable,
  input  logic            park_hiz,
  input  logic            div_pin_n,
  input  logic            reg_div_n,
  output logic [NOUT-1:0] out_t,
  output logic [NOUT-1:0] out_c,
  output logic [NOUT-1:0] drv_t,
  output logic [NOUT-1:0] drv_c
);
  localparam int SW     = NOUT + 2;
  localparam int STOP_B = NOUT;
  localparam int DIV_B  = NOUT + 1;

  logic [SW-1:0]   sync_q;
  logic [NOUT-1:0] oe_act;
  logic            stop_act, div_req, stop_ok;
  logic            ref_next, rise_ev, fall_ev;

  pin_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({div_pin_n, stop_pin, oe_pin}),
    .q   (sync_q)
  );

  always_comb begin
    stop_act = pol_strap ? sync_q[STOP_B] : ~sync_q[STOP_B];
    oe_act   = pol_strap ? ~sync_q[NOUT-1:0] : sync_q[NOUT-1:0];
    div_req  = ~sync_q[DIV_B] | ~reg_div_n;
  end

  rate_gen u_rate (
    .clk      (clk),
    .rst      (rst),
    .div_req  (div_req),
    .ref_next (ref_next),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev)
  );

  // complement rising edge == true falling edge
  stop_debounce u_dbn (
    .clk    (clk),
    .rst    (rst),
    .sample (fall_ev),
    .level  (stop_act),
    .held   (stop_ok)
  );

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    out_gate u_gate (
      .clk      (clk),
      .rst      (rst),
      .rise_ev  (rise_ev),
      .fall_ev  (fall_ev),
      .ref_next (ref_next),
      .en       (oe_act[i] & reg_en[i]),
      .stop_req (stop_ok & reg_stoppable[i]),
      .park_hiz (park_hiz),
      .o_t      (out_t[i]),
      .o_c      (out_c[i]),
      .d_t      (drv_t[i]),
      .d_c      (drv_c[i])
    );
  end
endmodule

// File: rtl/clkout_gate_ctrl_chk.sv
module clkout_gate_ctrl_chk #(
  parameter int NOUT = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [NOUT-1:0] reg_stoppable,
  input logic [NOUT-1:0] out_t,
  input logic [NOUT-1:0] out_c,
  input logic [NOUT-1:0] drv_t,
  input logic [NOUT-1:0] drv_c
);
  logic [NOUT-1:0] park;
  assign park = drv_t & ~drv_c;

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (drv_t == '0 && drv_c == '0 && out_t == '0 && out_c == '0));

  // R6
  resume_together_chk: assert property (@(posedge clk) disable iff (rst)
    (|($past(park & reg_stoppable) & drv_c)) |-> !(|($past(park & reg_stoppable) & park)));

  for (genvar i = 0; i < NOUT; i++) begin : g_chk
    // R4
    park_level_chk: assert property (@(posedge clk) disable iff (rst)
      park[i] |-> (out_t[i] && !out_c[i]));
    // R4
    comp_needs_true_chk: assert property (@(posedge clk) disable iff (rst)
      drv_c[i] |-> drv_t[i]);
    // R10
    comp_inverse_chk: assert property (@(posedge clk) disable iff (rst)
      drv_c[i] |-> (out_c[i] != out_t[i]));
    // R8
    restart_low_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(drv_c[i]) |-> !out_t[i]);
    // R3
    nonstop_free_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(drv_c[i]) && !$past(reg_stoppable[i])) |-> !park[i]);
  end
endmodule

bind clkout_gate_ctrl clkout_gate_ctrl_chk #(.NOUT(NOUT)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .reg_stoppable (reg_stoppable),
  .out_t         (out_t),
  .out_c         (out_c),
  .drv_t         (drv_t),
  .drv_c         (drv_c)
);

// File: tb/test_clkout_gate_ctrl.sv
module test_clkout_gate_ctrl;
  localparam int NOUT   = 8;
  localparam int CLK_NS = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            stop_pin = 1'b1;
  logic [NOUT-1:0] oe_pin = '1;
  logic            pol_strap = 1'b0;
  logic [NOUT-1:0] reg_en = '1;
  logic [NOUT-1:0] reg_stoppable = '0;
  logic            park_hiz = 1'b0;
  logic            div_pin_n = 1'b1;
  logic            reg_div_n = 1'b1;
  logic [NOUT-1:0] out_t, out_c, drv_t, drv_c;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_NS/2) clk = ~clk;

  clkout_gate_ctrl #(.NOUT(NOUT)) i_clkout_gate_ctrl (
    .clk(clk), .rst(rst), .stop_pin(stop_pin), .oe_pin(oe_pin),
    .pol_strap(pol_strap), .reg_en(reg_en), .reg_stoppable(reg_stoppable),
    .park_hiz(park_hiz), .div_pin_n(div_pin_n), .reg_div_n(reg_div_n),
    .out_t(out_t), .out_c(out_c), .drv_t(drv_t), .drv_c(drv_c)
  );

  function automatic logic [7:0] rot8(input logic [7:0] v, input int k);
    return 8'((v << k) | (v >> (8 - k)));
  endfunction

  task automatic run_case(input logic strap, input logic hiz, input int rate,
                          input logic stop_on, input int k);
    logic [7:0] en_l, rg, stp;
    logic [7:0] ot [17];
    logic [7:0] oc [17];
    logic [7:0] dt [17];
    logic [7:0] dc [17];
    en_l = rot8(8'hF0, k);
    rg   = rot8(8'hCC, k);
    stp  = rot8(8'hAA, k);
    @(negedge clk);
    pol_strap     = strap;
    park_hiz      = hiz;
    oe_pin        = strap ? ~en_l : en_l;
    reg_en        = rg;
    reg_stoppable = stp;
    stop_pin      = strap ? stop_on : ~stop_on;
    div_pin_n     = (rate == 1) ? 1'b0 : 1'b1;
    reg_div_n     = (rate == 2) ? 1'b0 : 1'b1;
    repeat (40) @(negedge clk);
    for (int c = 0; c < 17; c++) begin
      ot[c] = out_t; oc[c] = out_c; dt[c] = drv_t; dc[c] = drv_c;
      @(negedge clk);
    end
    for (int i = 0; i < NOUT; i++) begin
      bit ok = 1;
      int tog = 0;
      int exp_tog;
      string tag, cls;
      exp_tog = (rate != 0) ? 8 : 16;
      for (int c = 1; c < 17; c++) if (ot[c][i] != ot[c-1][i]) tog++;
      if (!(en_l[i] && rg[i])) begin
        tag = "R5"; cls = "off";
        for (int c = 0; c < 17; c++)
          if (dt[c][i] || dc[c][i] || ot[c][i] || oc[c][i]) ok = 0;
        exp_tog = 0;
      end else if (stop_on && stp[i]) begin
        tag = "R4"; cls = "parked";
        for (int c = 0; c < 17; c++)
          if (dt[c][i] != ~hiz || dc[c][i] || ot[c][i] != ~hiz || oc[c][i]) ok = 0;
        exp_tog = 0;
      end else begin
        tag = stop_on ? "R3" : "R7/R10";
        cls = "running";
        for (int c = 0; c < 17; c++)
          if (!dt[c][i] || !dc[c][i] || oc[c][i] == ot[c][i]) ok = 0;
      end
      if (tog != exp_tog) ok = 0;
      checks++;
      if (!ok) begin
        errors++;
        $display("FAIL %s (R2 strap=%0d hiz=%0d rate=%0d stop=%0d k=%0d) out%0d: got drv_t=%b drv_c=%b out_t=%b toggles=%0d, expected %s toggles=%0d",
                 tag, strap, hiz, rate, stop_on, k, i, dt[0][i], dc[0][i], ot[0][i], tog, cls, exp_tog);
      end
    end
  endtask

  // R1: a short stop pulse must not park anything
  task automatic pulse_case(input logic div, input int width);
    bit ok = 1;
    @(negedge clk);
    pol_strap = 0; park_hiz = 0; oe_pin = '1; reg_en = '1; reg_stoppable = '1;
    stop_pin = 1; div_pin_n = 1; reg_div_n = ~div;
    repeat (40) @(negedge clk);
    stop_pin = 0;
    repeat (width) @(negedge clk);
    stop_pin = 1;
    for (int c = 0; c < 30; c++) begin
      if (drv_c != '1) ok = 0;
      @(negedge clk);
    end
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R1 pulse width %0d div=%0d: got drv_c=%h, expected ff throughout", width, div, drv_c);
    end
  endtask

  // R6/R8: release of a parked set
  task automatic resume_case(input logic div);
    int lat = 0;
    int lim;
    lim = div ? 24 : 12;
    @(negedge clk);
    pol_strap = 0; park_hiz = 0; oe_pin = '1; reg_en = '1; reg_stoppable = '1;
    stop_pin = 0; div_pin_n = 1; reg_div_n = ~div;
    repeat (40) @(negedge clk);
    checks++;
    if (drv_c != '0 || drv_t != '1 || out_t != '1) begin
      errors++;
      $display("FAIL R4 parked set: got drv_t=%h drv_c=%h out_t=%h, expected ff 00 ff", drv_t, drv_c, out_t);
    end
    stop_pin = 1;
    while (drv_c == '0 && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    checks++;
    if (drv_c != '1 || lat > lim) begin
      errors++;
      $display("FAIL R6 resume div=%0d: got drv_c=%h after %0d cycles, expected ff within %0d", div, drv_c, lat, lim);
    end
    checks++;
    if (out_t != '0) begin
      errors++;
      $display("FAIL R8 first value after resume: got out_t=%h, expected 00", out_t);
    end
  endtask

  // R8/R7: repeated rate switches never stretch a phase
  task automatic switch_case();
    int run = 0;
    int worst = 0;
    logic last;
    int wait_cyc = 0;
    bit seen2 = 0;
    @(negedge clk);
    pol_strap = 0; park_hiz = 0; oe_pin = '1; reg_en = '1; reg_stoppable = '0;
    stop_pin = 1; div_pin_n = 1; reg_div_n = 1;
    repeat (40) @(negedge clk);
    last = out_t[0];
    for (int c = 0; c < 160; c++) begin
      if (c % 13 == 0) reg_div_n = ~reg_div_n;
      @(negedge clk);
      if (out_t[0] == last) run++;
      else begin
        if (run + 1 > worst) worst = run + 1;
        run = 0;
      end
      last = out_t[0];
    end
    checks++;
    if (worst > 2) begin
      errors++;
      $display("FAIL R8 phase length during rate switches: got %0d, expected at most 2", worst);
    end
    reg_div_n = 1;
    repeat (40) @(negedge clk);
    reg_div_n = 0;
    run = 0;
    last = out_t[0];
    while (!seen2 && wait_cyc < 60) begin
      @(negedge clk);
      wait_cyc++;
      if (out_t[0] == last) begin
        run++;
        if (last && run >= 1) seen2 = 1;
      end else run = 0;
      last = out_t[0];
    end
    checks++;
    if (!seen2 || wait_cyc > 28) begin
      errors++;
      $display("FAIL R7 rate switch latency: got %0d cycles, expected a 2-cycle high within 28", wait_cyc);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (drv_t != '0 || drv_c != '0 || out_t != '0 || out_c != '0) begin
      errors++;
      $display("FAIL R9 reset state: got drv_t=%h drv_c=%h out_t=%h out_c=%h, expected all 00",
               drv_t, drv_c, out_t, out_c);
    end
    rst = 1'b0;
    for (int s = 0; s < 2; s++)
      for (int h = 0; h < 2; h++)
        for (int r = 0; r < 3; r++)
          for (int p = 0; p < 2; p++)
            for (int k = 0; k < 3; k++)
              run_case(s[0], h[0], r, p[0], k);
    pulse_case(1'b0, 1);
    pulse_case(1'b1, 1);
    pulse_case(1'b1, 3);
    resume_case(1'b0);
    resume_case(1'b1);
    switch_case();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): got timeout, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule